// File: doc/BRIEF.md
# One-Time-Programmable Wiper Setting Controller

This block is the digital core of a two-channel, 256-step digital potentiometer. It keeps one 8-bit wiper register per channel and drives the two wiper codes straight to the resistor ladders. Commands arrive on a one-cycle parallel command port. A write sets a wiper. A read returns a wiper one cycle later. A write that also carries the program flag starts the single permanent commit of both wiper codes into write-once fuse storage.

The commit keeps the block busy for a parameterized number of cycles, `BUSY_CYCLES`, which stands for the long fuse-blowing interval. Writes that arrive while the block is busy are refused and flagged with an error pulse. When the interval ends, the `fuse_ok` input decides the outcome, and a two-bit validation code reports it. Only one attempt is ever allowed, whatever its outcome. After a good commit, writes still move the wipers, but each `power_on_reset` pulse brings back the fused codes. Without fused codes, a `power_on_reset` pulse returns the wipers to midscale. `rst_n` returns the whole block, fuses included, to the factory-fresh state.

The commit sequencer has four states:
- BLANK: no attempt has been made yet.
- BURN: the block is busy.
- FUSED: the commit succeeded.
- FAILED: the commit failed or was aborted.

It has four transitions:
- start: BLANK to BURN, on an accepted write with the program flag.
- burn_ok: BURN to FUSED, at the last busy cycle with `fuse_ok` high.
- burn_bad: BURN to FAILED, at the last busy cycle with `fuse_ok` low.
- burn_abort: BURN to FAILED, on `power_on_reset` during BURN.

FUSED and FAILED are terminal until `rst_n`.

Top module: `otp_wiper_ctrl`

## Requirements
- R1: After `rst_n`, both wipers read 0x80, `busy` is 0, `val_bits` is 00, and `cmd_err` and `rd_valid` are 0.
- R2: A write (`cmd_valid`=1, `cmd_write`=1) accepted while not busy loads `cmd_data` into the channel chosen by `cmd_chan` at the next edge. The other channel is left unchanged. Any number of writes is allowed.
- R3: A read (`cmd_valid`=1, `cmd_write`=0) gives `rd_valid`=1 in the next cycle, with `rd_data` equal to the addressed wiper value as it was before that edge. Reads are also served while busy.
- R4: A write with `cmd_prog`=1 in state BLANK writes its data and raises `busy` from the next cycle for exactly `BUSY_CYCLES` cycles.
- R5: A write arriving while `busy` is high changes no wiper, and `cmd_err` pulses high for one cycle in the next cycle.
- R6: `fuse_ok` is sampled in the last busy cycle. If it is 1, `val_bits` becomes 11 and both current wipers are stored in the fuses. If it is 0, `val_bits` becomes 10 and nothing is stored.
- R7: After any attempt (FUSED or FAILED), `cmd_prog` is ignored. `busy` stays 0, `val_bits` does not change, and the fuse contents do not change. The data still acts as an ordinary write.
- R8: With `val_bits`=11, writes change the wipers temporarily, and `power_on_reset` reloads both wipers with the fused codes at the next edge.
- R9: With `val_bits`≠11, `power_on_reset` sets both wipers to 0x80 at the next edge. A command in the same cycle as `power_on_reset` is dropped, and no `cmd_err` is raised.
- R10: `power_on_reset` during busy aborts the commit. `busy` falls at the next edge, `val_bits` becomes 10, and no fuse is stored.
- R11: `val_bits` never shows the reserved code 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low factory-fresh reset, clears the fuses too |
| power_on_reset | input | 1 | Power-cycle pulse: reload the wipers and abort any commit |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_prog | input | 1 | Program flag on a write: request the commit |
| cmd_chan | input | 1 | Channel select |
| cmd_data | input | 8 | Write data |
| fuse_ok | input | 1 | Fuse blow result, sampled in the last busy cycle |
| wiper_out | output | 16 | Live wiper codes, channel 0 in bits 7:0 |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| busy | output | 1 | Commit in progress |
| cmd_err | output | 1 | One-cycle pulse: a write was refused while busy |
| val_bits | output | 2 | Validation code: 00 none, 11 programmed, 10 failed |

## Verification
Two events can land in the same cycle:
- `power_on_reset` together with a command. The bench drives a write in the same cycle as the pulse and expects the write to vanish, with no error pulse.
- `power_on_reset` while a commit is in progress. The bench drives the pulse mid-burn and expects an immediate FAILED outcome with midscale wipers.

The bench also sends writes on every busy cycle, randomizing `fuse_ok` everywhere except the last cycle. It expects each refused write to yield an error pulse, and it expects the outcome to follow the last cycle only. A bench model of the sequencer predicts every output in every cycle.

// File: rtl/otp_wiper_pkg.sv
package otp_wiper_pkg;

    typedef enum logic [1:0] {
        ST_BLANK  = 2'd0,
        ST_BURN   = 2'd1,
        ST_FUSED  = 2'd2,
        ST_FAILED = 2'd3
    } commit_state_e;

    localparam logic [1:0] VAL_NONE = 2'b00;
    localparam logic [1:0] VAL_GOOD = 2'b11;
    localparam logic [1:0] VAL_BAD  = 2'b10;

endpackage

// File: rtl/otp_commit_fsm.sv
module otp_commit_fsm
    import otp_wiper_pkg::*;
#(
    parameter int BUSY_CYCLES = 40_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       por,
    input  logic       fuse_ok,
    output logic       busy,
    output logic       prog_open,
    output logic       fuse_set,
    output logic [1:0] val_bits
);
    localparam int CW = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;

    commit_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          last;

    assign last = (state_q == ST_BURN) && (cnt_q == '0);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK:  if (start) state_d = ST_BURN;
            ST_BURN: begin
                if (por)       state_d = ST_FAILED;
                else if (last) state_d = fuse_ok ? ST_FUSED : ST_FAILED;
            end
            ST_FUSED:  state_d = ST_FUSED;
            ST_FAILED: state_d = ST_FAILED;
        endcase
    end

    // state register and busy-interval counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BLANK;
            cnt_q   <= CW'(BUSY_CYCLES - 1);
        end else begin
            state_q <= state_d;
            if (state_q != ST_BURN) cnt_q <= CW'(BUSY_CYCLES - 1);
            else                    cnt_q <= cnt_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        prog_open = 1'b0;
        val_bits  = VAL_NONE;
        fuse_set  = last && fuse_ok && !por;
        unique case (state_q)
            ST_BLANK:  prog_open = 1'b1;
            ST_BURN:   busy      = 1'b1;
            ST_FUSED:  val_bits  = VAL_GOOD;
            ST_FAILED: val_bits  = VAL_BAD;
        endcase
    end

endmodule

// File: rtl/otp_fuse_bank.sv
module otp_fuse_bank #(
    parameter int W        = 8,
    parameter int CHANNELS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set,
    input  logic [CHANNELS*W-1:0] din,
    output logic [CHANNELS*W-1:0] dout,
    output logic                  blown
);
    // write-once: the first set wins, later ones are ignored
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= '0;
            blown <= 1'b0;
        end else if (set && !blown) begin
            dout  <= din;
            blown <= 1'b1;
        end
    end

endmodule

// File: rtl/otp_wiper_reg.sv
module otp_wiper_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         por,
    input  logic         use_fuse,
    input  logic [W-1:0] fuse_val,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= MID;
        else if (por)   q <= use_fuse ? fuse_val : MID;
        else if (wr_en) q <= wr_data;
    end

endmodule

// File: rtl/otp_wiper_ctrl.sv
module otp_wiper_ctrl #(
    parameter int W           = 8,
    parameter int CHANNELS    = 2,
    parameter int BUSY_CYCLES = 40_000_000,
    localparam int CH_W       = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  power_on_reset,
    input  logic                  cmd_valid,
    input  logic                  cmd_write,
    input  logic                  cmd_prog,
    input  logic [CH_W-1:0]       cmd_chan,
    input  logic [W-1:0]          cmd_data,
    input  logic                  fuse_ok,
    output logic [CHANNELS*W-1:0] wiper_out,
    output logic                  rd_valid,
    output logic [W-1:0]          rd_data,
    output logic                  busy,
    output logic                  cmd_err,
    output logic [1:0]            val_bits
);
    logic                  wr_ok, start, prog_open, fuse_set, fuse_blown;
    logic [CHANNELS*W-1:0] fuse_q;
    logic [W-1:0]          wiper_q [CHANNELS];

    assign wr_ok = cmd_valid && cmd_write && !busy && !power_on_reset;
    assign start = wr_ok && cmd_prog && prog_open;

    otp_commit_fsm #(.BUSY_CYCLES(BUSY_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .por      (power_on_reset),
        .fuse_ok  (fuse_ok),
        .busy     (busy),
        .prog_open(prog_open),
        .fuse_set (fuse_set),
        .val_bits (val_bits)
    );

    otp_fuse_bank #(.W(W), .CHANNELS(CHANNELS)) u_fuse (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (fuse_set),
        .din  (wiper_out),
        .dout (fuse_q),
        .blown(fuse_blown)
    );

    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        otp_wiper_reg #(.W(W)) u_wiper (
            .clk     (clk),
            .rst_n   (rst_n),
            .por     (power_on_reset),
            .use_fuse(fuse_blown),
            .fuse_val(fuse_q[c*W +: W]),
            .wr_en   (wr_ok && (cmd_chan == CH_W'(c))),
            .wr_data (cmd_data),
            .q       (wiper_q[c])
        );
        assign wiper_out[c*W +: W] = wiper_q[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            cmd_err  <= 1'b0;
        end else begin
            rd_valid <= cmd_valid && !cmd_write && !power_on_reset;
            rd_data  <= wiper_q[cmd_chan];
            cmd_err  <= cmd_valid && cmd_write && busy && !power_on_reset;
        end
    end

endmodule

// File: rtl/otp_wiper_ctrl_chk.sv
module otp_wiper_ctrl_chk #(
    parameter int W           = 8,
    parameter int CHANNELS    = 2,
    parameter int BUSY_CYCLES = 40_000_000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  power_on_reset,
    input logic                  cmd_valid,
    input logic                  cmd_write,
    input logic                  busy,
    input logic                  cmd_err,
    input logic [1:0]            val_bits,
    input logic [CHANNELS*W-1:0] wiper_out,
    input logic [CHANNELS*W-1:0] fuse_q,
    input logic                  fuse_blown
);
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    int unsigned run_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_cnt <= 0;
        else if (busy) run_cnt <= run_cnt + 1;
        else           run_cnt <= 0;
    end

    a_r4_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_cnt < BUSY_CYCLES);

    a_r5_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_write && busy && !power_on_reset |=> cmd_err);

    a_r5_wiper_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !power_on_reset |=> wiper_out == $past(wiper_out));

    a_r6_fused_code: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_blown |-> val_bits == 2'b11);

    a_r7_fuse_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_blown |=> fuse_blown && $stable(fuse_q));

    a_r8_por_reload: assert property (@(posedge clk) disable iff (!rst_n)
        power_on_reset && fuse_blown |=> wiper_out == $past(fuse_q));

    a_r9_por_mid: assert property (@(posedge clk) disable iff (!rst_n)
        power_on_reset && !fuse_blown |=> wiper_out == {CHANNELS{MID}});

    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        power_on_reset && busy |=> !busy && val_bits == 2'b10);

    a_r11_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        val_bits != 2'b01);

endmodule

bind otp_wiper_ctrl otp_wiper_ctrl_chk #(
    .W(W), .CHANNELS(CHANNELS), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .power_on_reset(power_on_reset),
    .cmd_valid     (cmd_valid),
    .cmd_write     (cmd_write),
    .busy          (busy),
    .cmd_err       (cmd_err),
    .val_bits      (val_bits),
    .wiper_out     (wiper_out),
    .fuse_q        (fuse_q),
    .fuse_blown    (fuse_blown)
);

// File: tb/otp_wiper_ctrl_test.sv
module otp_wiper_ctrl_test;
    localparam int W  = 8;
    localparam int CH = 2;
    localparam int BC = 16;
    localparam logic [W-1:0] MID = 8'h80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          power_on_reset = 1'b0;
    logic          cmd_valid = 1'b0, cmd_write = 1'b0, cmd_prog = 1'b0;
    logic [0:0]    cmd_chan = '0;
    logic [W-1:0]  cmd_data = '0;
    logic          fuse_ok = 1'b0;
    logic [CH*W-1:0] wiper_out;
    logic          rd_valid, busy, cmd_err;
    logic [W-1:0]  rd_data;
    logic [1:0]    val_bits;

    always #5 clk = ~clk;

    otp_wiper_ctrl #(.W(W), .CHANNELS(CH), .BUSY_CYCLES(BC)) uut (
        .clk(clk), .rst_n(rst_n), .power_on_reset(power_on_reset),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_prog(cmd_prog),
        .cmd_chan(cmd_chan), .cmd_data(cmd_data), .fuse_ok(fuse_ok),
        .wiper_out(wiper_out), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .cmd_err(cmd_err), .val_bits(val_bits)
    );

    int    checks = 0;
    int    errors = 0;
    string req = "R1";
    bit    finished = 1'b0;

    // reference model: 0 blank, 1 burn, 2 fused, 3 failed
    logic [W-1:0] m_w [CH];
    logic [W-1:0] m_f [CH];
    int           m_st;
    int           m_cnt;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_val();
        case (m_st)
            2:       return 2'b11;
            3:       return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    task automatic compare_all(bit rv, logic [W-1:0] rd, bit err);
        for (int c = 0; c < CH; c++) chk("wiper", 32'(wiper_out[c*W +: W]), 32'(m_w[c]));
        chk("busy", 32'(busy), 32'(m_st == 1));
        chk("val_bits", 32'(val_bits), 32'(exp_val()));
        chk("cmd_err", 32'(cmd_err), 32'(err));
        chk("rd_valid", 32'(rd_valid), 32'(rv));
        if (rv) chk("rd_data", 32'(rd_data), 32'(rd));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; power_on_reset = 1'b0; cmd_valid = 1'b0;
        cmd_write = 1'b0; cmd_prog = 1'b0; fuse_ok = 1'b0;
        for (int c = 0; c < CH; c++) begin m_w[c] = MID; m_f[c] = '0; end
        m_st = 0; m_cnt = 0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        req = "R1";
        compare_all(1'b0, '0, 1'b0);
    endtask

    task automatic cyc(bit v, bit wr, int ch, bit prog, logic [W-1:0] d, bit por, bit ok);
        bit busy_pre, rv, err;
        logic [W-1:0] rd;
        @(negedge clk);
        cmd_valid = v; cmd_write = wr; cmd_chan = 1'(ch); cmd_prog = prog;
        cmd_data = d; power_on_reset = por; fuse_ok = ok;
        @(posedge clk);
        #1;
        busy_pre = (m_st == 1);
        rv  = v && !wr && !por;
        rd  = m_w[ch];
        err = v && wr && busy_pre && !por;
        if (por) begin
            if (m_st == 1) m_st = 3;
            for (int c = 0; c < CH; c++) m_w[c] = (m_st == 2) ? m_f[c] : MID;
        end else if (busy_pre) begin
            if (m_cnt == 0) begin
                if (ok) begin
                    m_st = 2;
                    for (int c = 0; c < CH; c++) m_f[c] = m_w[c];
                end else m_st = 3;
            end else m_cnt--;
        end else if (v && wr) begin
            m_w[ch] = d;
            if (prog && m_st == 0) begin m_st = 1; m_cnt = BC - 1; end
        end
        compare_all(rv, rd, err);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100_000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired during %s", req);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0C0FFEE5));
        do_reset();

        // R2 R3 R9: random traffic before any commit
        for (int i = 0; i < 150; i++) begin
            bit wr  = 1'($urandom_range(0, 1));
            bit por = ($urandom_range(0, 19) == 0);
            req = por ? "R9" : (wr ? "R2" : "R3");
            cyc(1'b1, wr, int'($urandom_range(0, 1)), 1'b0, 8'($urandom), por, 1'b0);
        end
        req = "R2"; cyc(1, 1, 0, 0, 8'h00, 0, 0); cyc(1, 1, 1, 0, 8'hFF, 0, 0);
        req = "R3"; cyc(1, 0, 0, 0, 8'h00, 0, 0); cyc(1, 0, 1, 0, 8'h00, 0, 0);
        req = "R9"; cyc(1, 1, 0, 0, 8'h3A, 1, 0);   // write dropped by power-up
        cyc(0, 0, 0, 0, 8'h00, 0, 0);

        // Scenario A: abort by power-up during burn
        req = "R4"; cyc(1, 1, 0, 1, 8'h3C, 0, 1);
        for (int i = 0; i < 5; i++) begin req = "R3"; cyc(1, 0, i % 2, 0, 8'h00, 0, 1); end
        req = "R10"; cyc(0, 0, 0, 0, 8'h00, 1, 1);
        req = "R7"; cyc(1, 1, 1, 1, 8'h11, 0, 1); cyc(0, 0, 0, 0, 8'h00, 0, 1);
        cyc(0, 0, 0, 0, 8'h00, 1, 1);

        // Scenario B: fuse result bad in last busy cycle
        do_reset();
        req = "R4"; cyc(1, 1, 1, 1, 8'hA5, 0, 0);
        while (m_st == 1) begin
            bit ok = (m_cnt == 0) ? 1'b0 : 1'($urandom_range(0, 1));
            req = "R5";
            cyc(1, 1, int'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'($urandom), 0, ok);
        end
        req = "R6"; cyc(0, 0, 0, 0, 8'h00, 0, 0);
        req = "R9"; cyc(0, 0, 0, 0, 8'h00, 1, 0);

        // Scenario C: good commit, temporary overwrite, reload
        do_reset();
        req = "R2"; cyc(1, 1, 0, 0, 8'h01, 0, 0);
        req = "R4"; cyc(1, 1, 1, 1, 8'hFE, 0, 0);
        while (m_st == 1) begin
            bit ok = (m_cnt == 0) ? 1'b1 : 1'($urandom_range(0, 1));
            bit wr = 1'($urandom_range(0, 1));
            req = wr ? "R5" : "R3";
            cyc(1, wr, int'($urandom_range(0, 1)), 1'b0, 8'($urandom), 0, ok);
        end
        req = "R6"; cyc(0, 0, 0, 0, 8'h00, 0, 0);
        for (int i = 0; i < 60; i++) begin
            bit por = ($urandom_range(0, 9) == 0);
            req = "R8";
            cyc(1, 1'($urandom_range(0, 1)), int'($urandom_range(0, 1)), 1'b0,
                8'($urandom), por, 1'b0);
        end
        req = "R7"; cyc(1, 1, 0, 1, 8'h77, 0, 0); cyc(0, 0, 0, 0, 8'h00, 0, 0);
        req = "R8"; cyc(0, 0, 0, 0, 8'h00, 1, 0);
        chk("fused ch0", 32'(wiper_out[7:0]), 32'h01);
        chk("fused ch1", 32'(wiper_out[15:8]), 32'hFE);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule